// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block sits between a processor's load path and a slower word-wide memory. It keeps a small number of words close to the processor. The word address is split into a set index, taken from its low bits, and a tag, taken from the remaining high bits. Each set holds two lines of one word each. On every request, both lines of the indexed set are checked against the tag at the same time.

A request that finds its word is answered in the same cycle, with no stall. A request that does not find its word raises the stall output and starts a single-word read on the memory port. When the memory acknowledges, the returned word is written into one line of the set and handed to the processor.

The line that receives the new word is chosen as follows. An empty line in the set is always used first. If both lines are full, a single recency bit per set names the line that has gone longest without use. That bit moves to the other line each time a line is hit or filled.

Top module: `c2w_read_cache`

## Requirements
- R1: The set index is the word address modulo SETS, which is the low log2(SETS) address bits. The tag is the remaining high bits. Two addresses with the same index but different tags are distinct blocks.
- R2: A request (`cpu_req`=1 while the block is not busy) whose word is held in either line of its set gives `cpu_hit`=1, `cpu_stall`=0, `cpu_rdata` equal to the stored word, and `mem_req`=0, all in that same cycle.
- R3: A request that misses raises `cpu_stall` in its own cycle. From the next cycle, `mem_req`=1 with `mem_addr` equal to the requested address. Both stay unchanged, with `cpu_stall` high, until a cycle in which `mem_ack`=1.
- R4: The cycle after `mem_ack` gives `cpu_stall`=0, `cpu_hit`=0 and `cpu_rdata` equal to the `mem_rdata` sampled with the acknowledge. That cycle completes the request. A later request to the same address hits.
- R5: On a miss, an empty line of the set is filled before any full line is replaced. A block is never held in both lines of a set.
- R6: When both lines of the set are full, the line that has gone longest without a hit or a fill is replaced. Hits and fills both count as uses.
- R7: Reset empties every line and clears every recency bit. After reset, `mem_req` and `cpu_stall` are low while no request is present, and the first request to any address misses.
- R8: With two sets, the block sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss.
- R9: While `cpu_req`=0 and the block is idle, no line or recency bit changes, and `cpu_stall`, `cpu_hit` and `mem_req` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request, held with its address until a cycle with `cpu_stall`=0 |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_stall | output | 1 | High while the current request is not yet answered |
| cpu_hit | output | 1 | High when the request is answered from a stored line this cycle |
| cpu_rdata | output | DATA_W | Read word, valid when `cpu_req`=1 and `cpu_stall`=0 |
| mem_req | output | 1 | Memory read request for the missing word |
| mem_addr | output | ADDR_W | Word address of the memory read |
| mem_ack | input | 1 | Memory answer strobe, one cycle, only while `mem_req`=1 |
| mem_rdata | input | DATA_W | Memory word, valid with `mem_ack` |

## Verification
The short sequence 0, 8, 0, 6, 8 in a single set separates true least-recently-used replacement from round-robin or fixed-way replacement. Those policies would keep block 8 or evict block 0 at the wrong time. Pairs of addresses that share an index but differ only in the top address bits check that the full tag is compared. Sequences with idle cycles and changing addresses show that an inactive request leaves the contents alone. A long pseudo-random stream over a few colliding addresses, with memory latencies from zero to three cycles, is compared cycle by cycle against a list-based recency model. It catches errors in the victim choice, the recency update on hits and the fill timing.

// File: rtl/c2w_pkg.sv
package c2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } c2w_state_e;

    localparam int unsigned C2W_WAYS = 2;

endpackage

// File: rtl/c2w_way_store.sv
// One way of the cache: valid, tag and data per set, read asynchronously.
module c2w_way_store #(
    parameter int unsigned SETS   = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned TAG_W  = 13,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic [SETS-1:0]             vld;
        logic [SETS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx] = 1'b1;
            st_d.tag[wr_idx] = wr_tag;
            st_d.dat[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.vld[rd_idx];
    assign rd_tag   = st_q.tag[rd_idx];
    assign rd_data  = st_q.dat[rd_idx];

endmodule

// File: rtl/c2w_tag_match.sv
// Per-way tag comparator.
module c2w_tag_match #(
    parameter int unsigned TAG_W = 13
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             match
);

    always_comb begin
        match = line_valid && (line_tag == req_tag);
    end

endmodule

// File: rtl/c2w_recency.sv
// One recency bit per set naming the next way to evict; victim choice.
module c2w_recency #(
    parameter int unsigned SETS  = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [1:0]       look_vld,
    output logic             victim,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way
);

    logic [SETS-1:0] old_d, old_q;

    always_comb begin
        old_d = old_q;
        if (touch_en) begin
            old_d[touch_idx] = ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
        end else begin
            old_q <= old_d;
        end
    end

    always_comb begin
        if (!look_vld[0]) begin
            victim = 1'b0;
        end else if (!look_vld[1]) begin
            victim = 1'b1;
        end else begin
            victim = old_q[look_idx];
        end
    end

endmodule

// File: rtl/c2w_read_cache.sv
// Two-way set-associative read cache, one word per line.
module c2w_read_cache
    import c2w_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_stall,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        c2w_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              way;
        logic [DATA_W-1:0] fill;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  miss_idx;
    logic [TAG_W-1:0]  miss_tag;

    logic [C2W_WAYS-1:0] line_vld;
    logic [TAG_W-1:0]    line_tag  [C2W_WAYS];
    logic [DATA_W-1:0]   line_data [C2W_WAYS];
    logic [C2W_WAYS-1:0] way_hit;
    logic [C2W_WAYS-1:0] way_wr;

    logic victim;
    logic fill_en;
    logic touch_en;
    logic touch_way;
    logic [IDX_W-1:0] touch_idx;

    assign req_idx  = cpu_addr[IDX_W-1:0];
    assign req_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign miss_idx = c_q.addr[IDX_W-1:0];
    assign miss_tag = c_q.addr[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < C2W_WAYS; w++) begin : g_way
        c2w_way_store #(
            .SETS   (SETS),
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (req_idx),
            .rd_valid (line_vld[w]),
            .rd_tag   (line_tag[w]),
            .rd_data  (line_data[w]),
            .wr_en    (way_wr[w]),
            .wr_idx   (miss_idx),
            .wr_tag   (miss_tag),
            .wr_data  (mem_rdata)
        );

        c2w_tag_match #(
            .TAG_W (TAG_W)
        ) u_match (
            .line_valid (line_vld[w]),
            .line_tag   (line_tag[w]),
            .req_tag    (req_tag),
            .match      (way_hit[w])
        );

        assign way_wr[w] = fill_en && (c_q.way == w[0]);
    end

    c2w_recency #(
        .SETS  (SETS),
        .IDX_W (IDX_W)
    ) u_recency (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (req_idx),
        .look_vld  (line_vld),
        .victim    (victim),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way)
    );

    always_comb begin
        c_d       = c_q;
        cpu_stall = 1'b0;
        cpu_hit   = 1'b0;
        cpu_rdata = '0;
        mem_req   = 1'b0;
        fill_en   = 1'b0;
        touch_en  = 1'b0;
        touch_idx = req_idx;
        touch_way = way_hit[1];

        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (|way_hit) begin
                        cpu_hit   = 1'b1;
                        cpu_rdata = way_hit[1] ? line_data[1] : line_data[0];
                        touch_en  = 1'b1;
                    end else begin
                        cpu_stall = 1'b1;
                        c_d.st    = ST_FETCH;
                        c_d.addr  = cpu_addr;
                        c_d.way   = victim;
                    end
                end
            end
            ST_FETCH: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                if (mem_ack) begin
                    fill_en   = 1'b1;
                    touch_en  = 1'b1;
                    touch_idx = miss_idx;
                    touch_way = c_q.way;
                    c_d.fill  = mem_rdata;
                    c_d.st    = ST_DONE;
                end
            end
            ST_DONE: begin
                cpu_rdata = c_q.fill;
                c_d.st    = ST_IDLE;
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, addr: '0, way: 1'b0, fill: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_addr = c_q.addr;

endmodule

// File: rtl/c2w_read_cache_chk.sv
// Protocol and lookup checks, bound to the cache top.
module c2w_read_cache_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_stall,
    input logic              cpu_hit,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [1:0]        way_hit
);

    assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_hit |-> !cpu_stall && !mem_req);

    assert_miss_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_stall && !mem_req |=> mem_req && (mem_addr == $past(cpu_addr)));

    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_fetch_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);

    assert_fill_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !cpu_stall && !cpu_hit && (cpu_rdata == $past(mem_rdata)));

    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req && !mem_req |-> !cpu_stall && !cpu_hit);

endmodule

bind c2w_read_cache c2w_read_cache_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_stall (cpu_stall),
    .cpu_hit   (cpu_hit),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .way_hit   (way_hit)
);

// File: tb/tb_c2w_read_cache.sv
module tb_c2w_read_cache;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int SETS   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_stall;
    logic              cpu_hit;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    int n_vec  = 0;
    int n_fail = 0;
    int lcg    = 32'h1ace;

    // reference: per set, most and least recent block and fill count
    int m_new [SETS];
    int m_old [SETS];
    int m_cnt [SETS];

    always #2 clk = ~clk;

    c2w_read_cache #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SETS   (SETS)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_stall (cpu_stall),
        .cpu_hit   (cpu_hit),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [DATA_W-1:0] memf(input int a);
        return DATA_W'(a * 32'h9E3779B1 + 32'h01234567);
    endfunction

    function automatic bit model_access(input int a);
        int s = a % SETS;
        if (m_cnt[s] > 0 && m_new[s] == a) return 1'b1;
        if (m_cnt[s] > 1 && m_old[s] == a) begin
            m_old[s] = m_new[s];
            m_new[s] = a;
            return 1'b1;
        end
        if (m_cnt[s] > 0) m_old[s] = m_new[s];
        m_new[s] = a;
        if (m_cnt[s] < 2) m_cnt[s]++;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_req = 1'b0; mem_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            m_cnt[s] = 0; m_new[s] = -1; m_old[s] = -1;
        end
        #1;
        chk(cpu_stall == 1'b0, "R7", "stall after reset", 32'(cpu_stall), 0);
        chk(mem_req == 1'b0, "R7", "mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic idle_cycle(input int junk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_addr = ADDR_W'(junk); mem_ack = 1'b0;
        #1;
        chk(!cpu_stall && !cpu_hit && !mem_req, "R9", "idle outputs",
            {29'd0, cpu_stall, cpu_hit, mem_req}, 0);
    endtask

    // one full access; req names the requirement the hit/miss outcome tests
    task automatic access(input int a, input int lat, input string req, output bit saw_hit);
        bit exp_hit = model_access(a);
        int n = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = ADDR_W'(a); mem_ack = 1'b0;
        #1;
        saw_hit = cpu_hit;
        chk(cpu_hit == exp_hit, req, $sformatf("hit flag addr %0d", a), 32'(cpu_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk(!cpu_stall && !mem_req, "R2", "no stall on hit", {30'd0, cpu_stall, mem_req}, 0);
            chk(cpu_rdata == memf(a), "R2", "hit data", cpu_rdata, memf(a));
        end else begin
            chk(cpu_stall && !mem_req, "R3", "miss stall cycle", {30'd0, cpu_stall, mem_req}, 2);
            forever begin
                @(negedge clk);
                if (mem_req && n >= lat) begin
                    mem_ack = 1'b1; mem_rdata = memf(int'(mem_addr));
                end else begin
                    mem_ack = 1'b0;
                end
                n++;
                #1;
                chk(mem_req && cpu_stall, "R3", "fetch req and stall", {30'd0, mem_req, cpu_stall}, 3);
                chk(mem_addr == ADDR_W'(a), "R3", "fetch address", 32'(mem_addr), a);
                if (mem_ack) break;
                if (n > 40) begin
                    chk(1'b0, "R3", "memory request never seen", 0, 1);
                    break;
                end
            end
            @(negedge clk);
            mem_ack = 1'b0;
            #1;
            chk(!cpu_stall && !cpu_hit, "R4", "release after fill", {30'd0, cpu_stall, cpu_hit}, 0);
            chk(cpu_rdata == memf(a), "R4", "fill data", cpu_rdata, memf(a));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        bit h;
        int seq [5] = '{0, 8, 0, 6, 8};
        bit exp_seq [5] = '{0, 0, 1, 0, 0};

        do_reset();

        // R8: fixed sequence in one set; R6 recency on hits and fills
        for (int i = 0; i < 5; i++) begin
            access(seq[i], i % 3, "R6", h);
            chk(h == exp_seq[i], "R8", $sformatf("sequence step %0d", i), 32'(h), 32'(exp_seq[i]));
        end
        access(6, 0, "R6", h);   // 6 and 8 resident
        access(8, 1, "R6", h);
        access(0, 2, "R6", h);   // evicts 6

        // R1: same low bits, differing high tag bits
        access(1, 0, "R1", h);
        access(513, 1, "R1", h);
        access(1, 0, "R1", h);
        access(513, 0, "R1", h);
        access(3, 3, "R1", h);

        // R5: both lines of a set fill before any replacement
        access(4, 0, "R5", h);
        access(2, 1, "R5", h);
        access(4, 0, "R5", h);
        access(2, 0, "R5", h);

        // R9: idle cycles with moving address leave contents alone
        for (int i = 0; i < 6; i++) idle_cycle(i * 37);
        access(4, 0, "R9", h);
        access(2, 0, "R9", h);

        // R7: reset empties every line
        do_reset();
        access(4, 0, "R7", h);
        access(2, 0, "R7", h);
        access(4, 0, "R7", h);

        // R6: long pseudo-random stream over colliding addresses
        for (int i = 0; i < 400; i++) begin
            int a;
            lcg = lcg * 1103515245 + 12345;
            a = ((lcg >>> 16) & 7) + (((lcg >>> 20) & 1) * 512);
            if (((lcg >>> 24) & 7) == 0) idle_cycle(lcg >>> 8);
            access(a, (lcg >>> 26) & 3, "R6", h);
        end

        @(negedge clk);
        cpu_req = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule